// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Sequencer

This block sits between a synchronous host and an external asynchronous static RAM organised as three 8-bit lanes, each gated by its own active-low select. The host presents one request per handshake: an address, a read/write flag and, for writes, 24 bits of data and a 3-bit lane mask. The block turns each request into a strobe sequence whose lengths are set by parameters in whole clock cycles. Every memory-side output comes from a register, so the strobes are free of glitches. The data bus goes to an external tri-state buffer through a separate drive-enable.

After reset the block waits out the RAM's power-up interval, which is `PWRUP_CYC` cycles and nominally 1 us. During this wait it refuses requests. A write holds the output enable high for its whole duration, so the bus never has to turn around inside the write. A read is always followed by one turnaround cycle before the block drives the bus again.

The state machine has six states:
- `ST_PWRUP` goes to `ST_IDLE` when the power-up timer expires.
- `ST_IDLE` goes to `ST_READ` on an accepted read, and to `ST_WRITE` on an accepted write with a non-zero mask. It stays in `ST_IDLE` on an accepted write with an all-zero mask.
- `ST_WRITE` goes to `ST_WHOLD` when the phase timer expires, and `ST_WHOLD` returns to `ST_IDLE` after one cycle.
- `ST_READ` goes to `ST_TURN` when the phase timer expires, capturing the read data on that edge, and `ST_TURN` returns to `ST_IDLE` after one cycle.

Top module: `sram_lane_ctrl`

## Requirements
- R1: During reset and for exactly `PWRUP_CYC` clock edges after reset is released, `ready` is low and every strobe is inactive (`mem_we_n`, `mem_oe_n` and all `mem_sel_n` high, `mem_dq_oe` low).
- R2: A request is accepted on a rising edge where `req_valid` and `ready` are both high. From the next cycle `ready` stays low until the access finishes. While `ready` is high, all strobes are inactive.
- R3: On a write, mask bit i selects lane i, which is data bits [8i+7:8i] and `mem_sel_n[i]`. A selected lane has its select driven low and an unselected lane keeps its select high. `mem_we_n` is low for exactly `WR_CYC` cycles, and the selects return high on the same edge as `mem_we_n`.
- R4: While `mem_we_n` is low, `mem_oe_n` is high and `mem_dq_oe` is high. The bus stays driven for one hold cycle after the write strobe ends. `mem_addr` does not change while the write strobe is low.
- R5: A write with an all-zero mask never lowers `mem_we_n`, keeps `ready` high, and leaves the memory contents unchanged.
- R6: A read lowers all three selects and `mem_oe_n` for exactly `RD_CYC` cycles with `mem_we_n` high. `mem_dq_in` is registered into `rdata` on the edge that ends that window, and `rvalid` is high for that one following cycle only.
- R7: `mem_dq_oe` is never high while `mem_oe_n` is low. After every read, at least one cycle with `mem_oe_n` high and `mem_dq_oe` low comes before the bus is driven again.
- R8: `ready` is low for `WR_CYC+1` cycles per write with a non-zero mask, and for `RD_CYC+1` cycles per read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | LANES*LANE_W | Write data |
| req_lanes | input | LANES | Write lane mask, bit i = lane i |
| ready | output | 1 | Block can accept a request this cycle |
| rdata | output | LANES*LANE_W | Registered read data |
| rvalid | output | 1 | One-cycle pulse: `rdata` holds new data |
| mem_addr | output | ADDR_W | Address to the RAM |
| mem_sel_n | output | LANES | Active-low lane selects |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | LANES*LANE_W | Data toward the RAM |
| mem_dq_oe | output | 1 | Drive-enable for the external data buffer |
| mem_dq_in | input | LANES*LANE_W | Data returned from the RAM |

## Verification
The bench writes a distinct arithmetic pattern to every address of an 8-word configuration with the full mask and reads the whole space back. This shows that addressing and the read capture edge are right. It then walks all eight mask values, each on its own address, overwriting the word with the complement pattern and reading it straight back. The merged result shows which selects went low, and the all-zero mask shows that a masked-out write leaves the word untouched. Each read is followed at once by a write, so the read-to-drive turnaround and the ready occupancy counts are checked against the parameters on every access.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_PWRUP = 3'd0,
        ST_IDLE  = 3'd1,
        ST_WRITE = 3'd2,
        ST_WHOLD = 3'd3,
        ST_READ  = 3'd4,
        ST_TURN  = 3'd5
    } sram_state_e;

endpackage

// File: rtl/sram_pwrup_wait.sv
// Counts the power-up interval once after reset; done stays high afterwards.
module sram_pwrup_wait #(
    parameter int PWRUP_CYC = 200
) (
    input  logic clk,
    input  logic rst,
    output logic done
);
    localparam int CNT_W = $clog2(PWRUP_CYC + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PWRUP_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = (cnt_q == LAST);
endmodule

// File: rtl/sram_phase_timer.sv
// Down-counter that measures the length of a strobe phase.
module sram_phase_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_lane_map.sv
// Maps the lane mask and access type to active-low lane selects.
module sram_lane_map #(
    parameter int LANES = 3
) (
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [LANES-1:0] mask,
    output logic [LANES-1:0] sel_n
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign sel_n[i] = !(rd_en || (wr_en && mask[i]));
    end
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W    = 19,
    parameter int LANES     = 3,
    parameter int LANE_W    = 8,
    parameter int PWRUP_CYC = 200,
    parameter int WR_CYC    = 2,
    parameter int RD_CYC    = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req_valid,
    input  logic                      req_write,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic [LANES*LANE_W-1:0]   req_wdata,
    input  logic [LANES-1:0]          req_lanes,
    output logic                      ready,
    output logic [LANES*LANE_W-1:0]   rdata,
    output logic                      rvalid,
    output logic [ADDR_W-1:0]         mem_addr,
    output logic [LANES-1:0]          mem_sel_n,
    output logic                      mem_we_n,
    output logic                      mem_oe_n,
    output logic [LANES*LANE_W-1:0]   mem_dq_out,
    output logic                      mem_dq_oe,
    input  logic [LANES*LANE_W-1:0]   mem_dq_in
);
    localparam int DATA_W = LANES * LANE_W;
    localparam int PH_MAX = (WR_CYC > RD_CYC) ? WR_CYC : RD_CYC;
    localparam int PH_W   = $clog2(PH_MAX + 1);

    sram_state_e      st_q, st_d;
    logic             pwr_done;
    logic             ph_load, ph_expired;
    logic [PH_W-1:0]  ph_val;
    logic             accept, wr_go, rd_go;
    logic [LANES-1:0] mask_q, mask_eff, sel_n_d;

    assign accept = req_valid && (st_q == ST_IDLE);
    assign wr_go  = accept && req_write && (|req_lanes);
    assign rd_go  = accept && !req_write;

    sram_pwrup_wait #(.PWRUP_CYC(PWRUP_CYC)) u_pwrup (
        .clk  (clk),
        .rst  (rst),
        .done (pwr_done)
    );

    sram_phase_timer #(.CNT_W(PH_W)) u_phase (
        .clk      (clk),
        .rst      (rst),
        .load     (ph_load),
        .load_val (ph_val),
        .expired  (ph_expired)
    );

    // Next-state logic
    always_comb begin
        st_d    = st_q;
        ph_load = 1'b0;
        ph_val  = '0;
        unique case (st_q)
            ST_PWRUP: if (pwr_done) st_d = ST_IDLE;
            ST_IDLE: begin
                if (rd_go) begin
                    st_d    = ST_READ;
                    ph_load = 1'b1;
                    ph_val  = PH_W'(RD_CYC - 1);
                end else if (wr_go) begin
                    st_d    = ST_WRITE;
                    ph_load = 1'b1;
                    ph_val  = PH_W'(WR_CYC - 1);
                end
            end
            ST_WRITE: if (ph_expired) st_d = ST_WHOLD;
            ST_WHOLD: st_d = ST_IDLE;
            ST_READ:  if (ph_expired) st_d = ST_TURN;
            ST_TURN:  st_d = ST_IDLE;
            default:  st_d = ST_PWRUP;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_PWRUP;
        else     st_q <= st_d;
    end

    assign mask_eff = wr_go ? req_lanes : mask_q;

    sram_lane_map #(.LANES(LANES)) u_lanes (
        .rd_en (st_d == ST_READ),
        .wr_en (st_d == ST_WRITE),
        .mask  (mask_eff),
        .sel_n (sel_n_d)
    );

    // Registered outputs, decoded from the next state
    always_ff @(posedge clk) begin
        if (rst) begin
            ready      <= 1'b0;
            mem_we_n   <= 1'b1;
            mem_oe_n   <= 1'b1;
            mem_sel_n  <= '1;
            mem_dq_oe  <= 1'b0;
            mem_addr   <= '0;
            mem_dq_out <= '0;
            mask_q     <= '0;
            rvalid     <= 1'b0;
            rdata      <= '0;
        end else begin
            ready     <= (st_d == ST_IDLE);
            mem_we_n  <= (st_d != ST_WRITE);
            mem_oe_n  <= (st_d != ST_READ);
            mem_sel_n <= sel_n_d;
            mem_dq_oe <= (st_d == ST_WRITE) || (st_d == ST_WHOLD);
            if (rd_go || wr_go) mem_addr <= req_addr;
            if (wr_go) begin
                mem_dq_out <= req_wdata;
                mask_q     <= req_lanes;
            end
            rvalid <= (st_q == ST_READ) && (st_d == ST_TURN);
            if ((st_q == ST_READ) && (st_d == ST_TURN)) rdata <= DATA_W'(mem_dq_in);
        end
    end
endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
    parameter int ADDR_W = 19,
    parameter int LANES  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              ready,
    input logic              rvalid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [LANES-1:0]  mem_sel_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_dq_oe
);
    // R4
    we_forces_oe_high_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (mem_oe_n && mem_dq_oe));

    // R7
    oe_blocks_drive_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> (!mem_dq_oe && mem_we_n));

    // R7
    read_turnaround_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_dq_oe) |-> ($past(mem_oe_n) && $past(mem_oe_n, 2)));

    // R6
    rvalid_single_chk: assert property (@(posedge clk) disable iff (rst)
        rvalid |=> !rvalid);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ready |-> (mem_we_n && mem_oe_n && (&mem_sel_n) && !mem_dq_oe));

    // R5
    write_has_lane_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> !(&mem_sel_n));

    // R3
    sel_rise_with_we_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (&mem_sel_n));

    // R4
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_addr));
endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ready     (ready),
    .rvalid    (rvalid),
    .mem_addr  (mem_addr),
    .mem_sel_n (mem_sel_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_lane_ctrl_test.sv
`timescale 1ns/100ps
module sram_lane_ctrl_test;
    localparam int AW = 3;
    localparam int NW = 1 << AW;
    localparam int PW = 12;
    localparam int WC = 2;
    localparam int RC = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [23:0] req_wdata = '0;
    logic [2:0]  req_lanes = '0;
    logic        ready, rvalid, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [23:0] rdata, mem_dq_out, mem_dq_in;
    logic [AW-1:0] mem_addr;
    logic [2:0]  mem_sel_n;

    logic [23:0] model  [NW];
    logic [23:0] golden [NW];
    int vectors = 0, fails = 0;

    always #2.5 clk = ~clk;

    sram_lane_ctrl #(.ADDR_W(AW), .LANES(3), .LANE_W(8), .PWRUP_CYC(PW),
                     .WR_CYC(WC), .RD_CYC(RC)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_lanes(req_lanes),
        .ready(ready), .rdata(rdata), .rvalid(rvalid), .mem_addr(mem_addr),
        .mem_sel_n(mem_sel_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // RAM model: lane i answers only when selected, reading, and not writing
    always_comb begin
        for (int i = 0; i < 3; i++)
            mem_dq_in[i*8 +: 8] = (!mem_sel_n[i] && !mem_oe_n && mem_we_n)
                                  ? model[mem_addr][i*8 +: 8] : 8'h00;
    end

    int  we_run = 0;
    logic prev_oe_n = 1'b1, prev_dq_oe = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (!mem_we_n) begin
                we_run++;
                for (int i = 0; i < 3; i++)
                    if (!mem_sel_n[i]) model[mem_addr][i*8 +: 8] <= mem_dq_out[i*8 +: 8];
                chk(mem_oe_n && mem_dq_oe, "R4 oe high and bus driven in write",
                    {30'd0, mem_oe_n, mem_dq_oe}, 32'd3);
            end else if (we_run != 0) begin
                chk(we_run == WC, "R3 write strobe length", we_run, WC);
                chk(&mem_sel_n, "R3 selects rise with strobe", mem_sel_n, 3'b111);
                chk(mem_dq_oe, "R4 hold cycle keeps bus driven", mem_dq_oe, 1);
                we_run = 0;
            end
            if (!mem_oe_n)
                chk(!mem_dq_oe, "R7 no drive while oe low", mem_dq_oe, 0);
            if (mem_dq_oe && !prev_dq_oe)
                chk(prev_oe_n, "R7 turnaround cycle before drive", prev_oe_n, 1);
            prev_oe_n  = mem_oe_n;
            prev_dq_oe = mem_dq_oe;
        end
    end

    function automatic logic [23:0] pat(input int a);
        return 24'h13579B + 24'h0A0B0C * 24'(a);
    endfunction

    task automatic wait_ready();
        int guard = 0;
        while (!ready && guard < 100) begin guard++; @(negedge clk); end
    endtask

    task automatic do_write(input int a, input logic [23:0] d, input logic [2:0] m);
        int low = 0;
        wait_ready();
        req_valid = 1; req_write = 1; req_addr = AW'(a); req_wdata = d; req_lanes = m;
        @(negedge clk);
        req_valid = 0;
        for (int i = 0; i < 3; i++)
            if (m[i]) golden[a][i*8 +: 8] = d[i*8 +: 8];
        if (m == 3'b000) begin
            chk(ready, "R5 zero-mask write keeps ready", ready, 1);
            chk(we_run == 0 && mem_we_n, "R5 no strobe on zero mask", mem_we_n, 1);
        end else begin
            while (!ready && low < 100) begin low++; @(negedge clk); end
            chk(low == WC + 1, "R8 write occupancy", low, WC + 1);
        end
    endtask

    task automatic do_read(input int a);
        int low = 0, pos = 0, pulses = 0;
        logic [23:0] got = '0;
        wait_ready();
        req_valid = 1; req_write = 0; req_addr = AW'(a);
        @(negedge clk);
        req_valid = 0;
        chk(!ready, "R2 ready drops after accept", ready, 0);
        chk(!mem_oe_n && mem_sel_n == 3'b000 && mem_we_n, "R6 read strobes",
            {mem_oe_n, mem_sel_n, mem_we_n}, 5'b00001);
        while (!ready && low < 100) begin
            low++;
            if (rvalid) begin pulses++; pos = low; got = rdata; end
            @(negedge clk);
        end
        chk(low == RC + 1, "R8 read occupancy", low, RC + 1);
        chk(pulses == 1 && pos == RC + 1, "R6 rvalid timing", pos, RC + 1);
        chk(got == golden[a], "R6 read data", got, golden[a]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        int pw_low = 0;
        for (int i = 0; i < NW; i++) begin model[i] = '0; golden[i] = '0; end
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!ready && !rvalid && mem_we_n && mem_oe_n && (&mem_sel_n) && !mem_dq_oe,
            "R1 reset state", {ready, rvalid, mem_dq_oe}, 0);
        rst = 0;
        while (!ready && pw_low < 1000) begin
            if (!(mem_we_n && mem_oe_n && (&mem_sel_n) && !mem_dq_oe))
                chk(0, "R1 strobes idle in power-up", mem_sel_n, 3'b111);
            pw_low++;
            @(negedge clk);
        end
        chk(pw_low == PW, "R1 power-up length", pw_low, PW);

        // Full-mask sweep then read-back
        for (int a = 0; a < NW; a++) do_write(a, pat(a), 3'b111);
        for (int a = 0; a < NW; a++) do_read(a);

        // Every mask on its own address: write, read back, write right after read
        for (int m = 0; m < 8; m++) begin
            do_write(m, ~pat(m), 3'(m));
            do_read(m);
            do_write((m + 1) % NW, pat(m + 5), 3'b111);
            do_read((m + 1) % NW);
        end

        for (int a = 0; a < NW; a++) do_read(a);
        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule